// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue. It takes one three-operand instruction written in scalar form (a destination and two sources) and expands it into a series of element operations. The program counter is held while the block is busy. Each operand carries a tag that marks it as vector or scalar. A vector operand's register index steps through consecutive registers, one per element. A scalar operand keeps its base register for the whole loop.

A start pulse captures the element count, the three base registers, the three tags, a predicate mask and a zeroing flag. After that, the block issues one element per clock. For each element it presents three register indices, a write strobe and a zero-write strobe. These feed a plain register file and an adder. When the loop ends, the block raises a one-cycle done pulse, and that pulse lets the program counter move on.

A scalar destination ends the loop at the first element that is written. With leading clear predicate bits, the vector sources are therefore walked forward to the first enabled element. This lets the predicate act as a source index.

Top module: `vec_elem_sequencer`

## Requirements
- R1: When `start` is sampled high while idle, the element loop begins on the next cycle. `busy` is high and `elem_idx` counts 0, 1, 2, ... one element per cycle. A `vl` above `MAX_VL` is treated as `MAX_VL`.
- R2: For a vector-tagged operand (tag = 1), the register index equals base + `elem_idx`, modulo 2^`IDX_W`.
- R3: For a scalar-tagged operand (tag = 0), the register index equals its base register on every element of the loop.
- R4: Element i is gated by `pred_mask` bit i, where bit 0 belongs to element 0. `wr_en` is high exactly when that bit is 1. A masked element still advances every vector operand index.
- R5: With `pred_en` = 0, the mask is taken as all ones, so every element asserts `wr_en`.
- R6: A masked element asserts `zero_en` when `zeroing` = 1. When `zeroing` = 0 it asserts neither strobe. `wr_en` and `zero_en` are never high together.
- R7: With a scalar destination, the loop ends right after the first element that asserts `wr_en`. The elements before it still step the vector sources.
- R8: With a scalar destination and `zeroing` = 1, a masked element asserts `zero_en` and the loop carries on.
- R9: `done` is a one-cycle pulse in the cycle after the last element, with `busy` low. With an effective `vl` of 0, `done` pulses in the cycle after `start` and no element is issued.
- R10: A `start` pulse while `busy` is high is ignored, and so are changes on the other inputs during the loop. The running loop keeps the values it captured.
- R11: During and after reset, `busy`, `done`, `wr_en` and `zero_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Capture an instruction and begin its loop |
| vl | input | VL_W (7) | Element count, 0 to MAX_VL |
| rt_base | input | IDX_W (7) | Destination base register |
| ra_base | input | IDX_W (7) | First source base register |
| rb_base | input | IDX_W (7) | Second source base register |
| rt_vec | input | 1 | Destination tag: 1 = vector, 0 = scalar |
| ra_vec | input | 1 | First source tag: 1 = vector, 0 = scalar |
| rb_vec | input | 1 | Second source tag: 1 = vector, 0 = scalar |
| pred_en | input | 1 | 1 = use `pred_mask`, 0 = all elements enabled |
| pred_mask | input | MAX_VL (64) | Per-element enable, bit i for element i |
| zeroing | input | 1 | Masked elements write zero |
| busy | output | 1 | An element is issued this cycle |
| elem_idx | output | VL_W (7) | Current element number |
| rt_idx | output | IDX_W (7) | Destination register for this element |
| ra_idx | output | IDX_W (7) | First source register for this element |
| rb_idx | output | IDX_W (7) | Second source register for this element |
| wr_en | output | 1 | Write the computed result |
| zero_en | output | 1 | Write zero to the destination |
| done | output | 1 | One-cycle pulse: the program counter may advance |

## Verification
The bench builds the block with its default parameters: `MAX_VL` = 64 and `IDX_W` = 7. With these values one loop can run the full 64 elements, and a `vl` of 100 reaches the clamp. A vector destination based at register 120 runs past the top of the 128-entry index space and wraps to 0. A 64-bit mask also lets the bench put the first set bit deep in the vector for the scalar-destination exit.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   localparam int NUM_OPS = 3;
   localparam int OP_RT   = 0;
   localparam int OP_RA   = 1;
   localparam int OP_RB   = 2;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/vseq_operand_idx.sv
module vseq_operand_idx #(
   parameter int IDX_W = 7,
   parameter int CNT_W = 7
) (
   input  logic [IDX_W-1:0] base,
   input  logic             is_vec,
   input  logic [CNT_W-1:0] count,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] step;

   generate
      if (CNT_W >= IDX_W) begin : g_trunc
         assign step = count[IDX_W-1:0];
      end else begin : g_ext
         assign step = {{(IDX_W-CNT_W){1'b0}}, count};
      end
   endgenerate

   assign idx = is_vec ? base + step : base;
endmodule

// File: rtl/vseq_pred_pick.sv
module vseq_pred_pick #(
   parameter int MAX_VL = 64,
   parameter int CNT_W  = 7
) (
   input  logic [MAX_VL-1:0] mask,
   input  logic [CNT_W-1:0]  count,
   output logic              bit_on
);
   localparam int SEL_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

   generate
      if (MAX_VL == 1) begin : g_single
         assign bit_on = mask[0];
      end else begin : g_multi
         logic [SEL_W-1:0] sel;
         assign sel    = count[SEL_W-1:0];
         assign bit_on = mask[sel];
      end
   endgenerate
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
   import vseq_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [CNT_W-1:0] vl_new,
   input  logic [CNT_W-1:0] vl_q,
   input  logic             dest_vec,
   input  logic             bit_on,
   output logic             running,
   output logic [CNT_W-1:0] count,
   output logic             done
);
   seq_state_e state;
   logic       last;

   assign running = (state == SEQ_RUN);
   assign last    = (count == (vl_q - CNT_W'(1))) || (!dest_vec && bit_on);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         count <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               count <= '0;
               if (accept) begin
                  if (vl_new == '0) done  <= 1'b1;
                  else              state <= SEQ_RUN;
               end
            end
            default: begin
               if (last) begin
                  state <= SEQ_IDLE;
                  done  <= 1'b1;
                  count <= '0;
               end else begin
                  count <= count + CNT_W'(1);
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/vec_elem_sequencer.sv
module vec_elem_sequencer
   import vseq_pkg::*;
#(
   parameter int MAX_VL = 64,
   parameter int IDX_W  = 7,
   parameter int VL_W   = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VL_W-1:0]   vl,
   input  logic [IDX_W-1:0]  rt_base,
   input  logic [IDX_W-1:0]  ra_base,
   input  logic [IDX_W-1:0]  rb_base,
   input  logic              rt_vec,
   input  logic              ra_vec,
   input  logic              rb_vec,
   input  logic              pred_en,
   input  logic [MAX_VL-1:0] pred_mask,
   input  logic              zeroing,
   output logic              busy,
   output logic [VL_W-1:0]   elem_idx,
   output logic [IDX_W-1:0]  rt_idx,
   output logic [IDX_W-1:0]  ra_idx,
   output logic [IDX_W-1:0]  rb_idx,
   output logic              wr_en,
   output logic              zero_en,
   output logic              done
);
   generate
      if (MAX_VL < 1) begin : g_bad_vl
         $error("MAX_VL must be at least 1");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be at least 1");
      end
      if (VL_W < $clog2(MAX_VL + 1)) begin : g_bad_vlw
         $error("VL_W too narrow for MAX_VL");
      end
   endgenerate

   logic [IDX_W-1:0]   base_q [NUM_OPS];
   logic [NUM_OPS-1:0] vec_q;
   logic [MAX_VL-1:0]  mask_q;
   logic               zero_q;
   logic [VL_W-1:0]    vl_q;
   logic [VL_W-1:0]    vl_clamped;
   logic               running;
   logic               accept;
   logic               bit_on;
   logic [VL_W-1:0]    count;
   logic [IDX_W-1:0]   idx_out [NUM_OPS];
   logic [IDX_W-1:0]   base_in [NUM_OPS];
   logic [NUM_OPS-1:0] vec_in;

   assign accept     = start && !running;
   assign vl_clamped = (vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl;

   assign base_in[OP_RT] = rt_base;
   assign base_in[OP_RA] = ra_base;
   assign base_in[OP_RB] = rb_base;
   assign vec_in = {rb_vec, ra_vec, rt_vec};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q  <= '0;
         mask_q <= '0;
         zero_q <= 1'b0;
         vl_q   <= '0;
         for (int k = 0; k < NUM_OPS; k++) base_q[k] <= '0;
      end else if (accept) begin
         vec_q  <= vec_in;
         mask_q <= pred_en ? pred_mask : '1;
         zero_q <= zeroing;
         vl_q   <= vl_clamped;
         for (int k = 0; k < NUM_OPS; k++) base_q[k] <= base_in[k];
      end
   end

   vseq_ctrl #(.CNT_W(VL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .vl_new   (vl_clamped),
      .vl_q     (vl_q),
      .dest_vec (vec_q[OP_RT]),
      .bit_on   (bit_on),
      .running  (running),
      .count    (count),
      .done     (done)
   );

   vseq_pred_pick #(.MAX_VL(MAX_VL), .CNT_W(VL_W)) u_pred (
      .mask   (mask_q),
      .count  (count),
      .bit_on (bit_on)
   );

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
         vseq_operand_idx #(.IDX_W(IDX_W), .CNT_W(VL_W)) u_idx (
            .base   (base_q[g]),
            .is_vec (vec_q[g]),
            .count  (count),
            .idx    (idx_out[g])
         );
      end
   endgenerate

   assign busy     = running;
   assign elem_idx = count;
   assign rt_idx   = idx_out[OP_RT];
   assign ra_idx   = idx_out[OP_RA];
   assign rb_idx   = idx_out[OP_RB];
   assign wr_en    = running && bit_on;
   assign zero_en  = running && !bit_on && zero_q;
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
   parameter int IDX_W = 7,
   parameter int VL_W  = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             wr_en,
   input logic             zero_en,
   input logic [VL_W-1:0]  elem_idx,
   input logic [IDX_W-1:0] rt_idx,
   input logic [IDX_W-1:0] ra_idx,
   input logic [IDX_W-1:0] rb_idx,
   input logic [2:0]       vec_tags,
   input logic             zero_mode
);
   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && zero_en));

   assert_no_zero_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !zero_mode) |-> !zero_en);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wr_en && !zero_en));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_elem_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (elem_idx == $past(elem_idx) + VL_W'(1)));

   assert_rt_march_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && vec_tags[0]) |-> (rt_idx == $past(rt_idx) + IDX_W'(1)));

   assert_ra_march_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && vec_tags[1]) |-> (ra_idx == $past(ra_idx) + IDX_W'(1)));

   assert_rb_march_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && vec_tags[2]) |-> (rb_idx == $past(rb_idx) + IDX_W'(1)));

   assert_ra_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !vec_tags[1]) |-> $stable(ra_idx));

   assert_rb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !vec_tags[2]) |-> $stable(rb_idx));

   assert_scalar_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && !vec_tags[0]) |=> !busy);
endmodule

bind vec_elem_sequencer vseq_checker #(.IDX_W(IDX_W), .VL_W(VL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .wr_en     (wr_en),
   .zero_en   (zero_en),
   .elem_idx  (elem_idx),
   .rt_idx    (rt_idx),
   .ra_idx    (ra_idx),
   .rb_idx    (rb_idx),
   .vec_tags  (vec_q),
   .zero_mode (zero_q)
);

// File: tb/sim_vec_elem_sequencer.sv
module sim_vec_elem_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  vl = '0;
   logic [6:0]  rt_base = '0, ra_base = '0, rb_base = '0;
   logic        rt_vec = 1'b0, ra_vec = 1'b0, rb_vec = 1'b0;
   logic        pred_en = 1'b0;
   logic [63:0] pred_mask = '0;
   logic        zeroing = 1'b0;
   logic        busy, wr_en, zero_en, done;
   logic [6:0]  elem_idx, rt_idx, ra_idx, rb_idx;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   vec_elem_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
      .rt_base(rt_base), .ra_base(ra_base), .rb_base(rb_base),
      .rt_vec(rt_vec), .ra_vec(ra_vec), .rb_vec(rb_vec),
      .pred_en(pred_en), .pred_mask(pred_mask), .zeroing(zeroing),
      .busy(busy), .elem_idx(elem_idx), .rt_idx(rt_idx), .ra_idx(ra_idx),
      .rb_idx(rb_idx), .wr_en(wr_en), .zero_en(zero_en), .done(done)
   );

   // vec field: bit 2 = destination, bit 1 = first source, bit 0 = second source
   typedef struct packed {
      logic [6:0]  vl;
      logic [6:0]  rt;
      logic [6:0]  ra;
      logic [6:0]  rb;
      logic [2:0]  vec;
      logic        pen;
      logic [63:0] mask;
      logic        zero;
   } vec_t;

   localparam int NROWS = 7;
   localparam vec_t TBL [NROWS] = '{
      '{7'd4,   7'd10,  7'd20, 7'd30, 3'b111, 1'b0, 64'h0,        1'b0},
      '{7'd6,   7'd40,  7'd50, 7'd60, 3'b111, 1'b1, 64'h2D,       1'b0},
      '{7'd6,   7'd40,  7'd50, 7'd60, 3'b111, 1'b1, 64'h2D,       1'b1},
      '{7'd5,   7'd8,   7'd2,  7'd3,  3'b100, 1'b1, 64'h9,        1'b0},
      '{7'd100, 7'd120, 7'd1,  7'd90, 3'b110, 1'b0, 64'h0,        1'b0},
      '{7'd8,   7'd5,   7'd6,  7'd7,  3'b011, 1'b1, 64'h0,        1'b0},
      '{7'd1,   7'd9,   7'd11, 7'd12, 3'b000, 1'b0, 64'h0,        1'b0}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic vec_t mk(input int n, input int rt, input int ra, input int rb,
                               input logic [2:0] vec, input logic pen,
                               input logic [63:0] mask, input logic zero);
      vec_t v;
      v.vl = 7'(n); v.rt = 7'(rt); v.ra = 7'(ra); v.rb = 7'(rb);
      v.vec = vec; v.pen = pen; v.mask = mask; v.zero = zero;
      return v;
   endfunction

   task automatic run(input vec_t v, input string tag, input int poke);
      int n_eff;
      int i;
      bit fin;
      @(negedge clk);
      vl = v.vl; rt_base = v.rt; ra_base = v.ra; rb_base = v.rb;
      rt_vec = v.vec[2]; ra_vec = v.vec[1]; rb_vec = v.vec[0];
      pred_en = v.pen; pred_mask = v.mask; zeroing = v.zero;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n_eff = (v.vl > 64) ? 64 : int'(v.vl);
      if (n_eff == 0) begin
         chk(done && !busy && !wr_en && !zero_en, {tag, " R9 vl0"},
             {busy, done, wr_en, zero_en}, 4'b0100);
         @(negedge clk);
         chk(!done && !busy, {tag, " R9 vl0 pulse"}, {busy, done}, 2'b00);
         return;
      end
      i = 0;
      fin = 0;
      while (!fin) begin
         logic bitv, ew, ez;
         logic [6:0] ert, era, erb;
         bitv = v.pen ? v.mask[i] : 1'b1;
         ew = bitv;
         ez = !bitv && v.zero;
         ert = v.vec[2] ? 7'(v.rt + i) : v.rt;
         era = v.vec[1] ? 7'(v.ra + i) : v.ra;
         erb = v.vec[0] ? 7'(v.rb + i) : v.rb;
         chk(busy && !done && elem_idx == 7'(i), {tag, " R1 elem"},
             {busy, done, elem_idx}, {1'b1, 1'b0, 7'(i)});
         chk({rt_idx, ra_idx, rb_idx} == {ert, era, erb}, {tag, " R2_R3 idx"},
             {rt_idx, ra_idx, rb_idx}, {ert, era, erb});
         chk({wr_en, zero_en} == {ew, ez}, {tag, " R4_R6 strobes"},
             {wr_en, zero_en}, {ew, ez});
         if (i == n_eff - 1 || (!v.vec[2] && bitv)) fin = 1;
         if (i == poke) begin
            start = 1'b1; vl = 7'd2; rt_base = 7'd99; ra_base = 7'd98; rb_base = 7'd97;
            rt_vec = ~v.vec[2]; ra_vec = ~v.vec[1]; rb_vec = ~v.vec[0];
            pred_en = 1'b1; pred_mask = ~v.mask; zeroing = ~v.zero;
         end
         @(negedge clk);
         start = 1'b0;
         i++;
      end
      chk(done && !busy && !wr_en && !zero_en, {tag, " R9 end"},
          {busy, done, wr_en, zero_en}, 4'b0100);
      @(negedge clk);
      chk(!done && !busy, {tag, " R9 pulse"}, {busy, done}, 2'b00);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(!busy && !done && !wr_en && !zero_en, "R11 in reset",
          {busy, done, wr_en, zero_en}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !wr_en && !zero_en, "R11 after reset",
          {busy, done, wr_en, zero_en}, 4'b0000);

      // table walk: full vectors, predication, zeroing, scalar sources, clamp and wrap
      for (int r = 0; r < NROWS; r++) run(TBL[r], $sformatf("row%0d R1", r), -1);

      // predicate off: all ones even if mask is zero
      run(mk(5, 1, 2, 3, 3'b111, 1'b0, 64'h0, 1'b1), "R5 nopred", -1);
      // scalar dest, first set bit at 3: sources stepped then exit
      run(mk(8, 4, 16, 32, 3'b011, 1'b1, 64'h8, 1'b0), "R7 sdest", -1);
      // scalar dest, set bit deep in the mask
      run(mk(64, 4, 0, 64, 3'b011, 1'b1, 64'h8000_0000_0000_0000, 1'b0), "R7 deep", -1);
      // scalar dest with zeroing: zero writes continue the loop
      run(mk(8, 4, 16, 32, 3'b010, 1'b1, 64'h20, 1'b1), "R8 szero", -1);
      // zero length
      run(mk(0, 1, 2, 3, 3'b111, 1'b1, 64'hF, 1'b0), "R9 zero", -1);
      // start pulse and input changes during a loop are ignored
      run(mk(6, 10, 20, 30, 3'b110, 1'b1, 64'h15, 1'b1), "R10 poke", 2);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule